// File: doc/BRIEF.md
# Link Buffer Flow Control (Credit and On/Off)

This block holds both halves of the buffer flow control for one router link that carries several virtual channels (VCs). On the sending side it decides, each cycle, whether a flit offered for a given VC may go onto the link. On the receiving side it tracks how full each VC's buffer is and produces the backpressure that travels back to the sender. The two halves are separate pieces of logic inside one top module. The wires between them are ports, so the integrator can put the link's forward and return pipeline stages in between.

Two schemes are available, selected by the `fc_mode` pin.

- **Credit mode.** The sender keeps one counter per VC of free slots downstream. Each flit sent lowers it by one. Each credit pulse returned by the receiver, one pulse per freed slot, raises it by one. The buffer must be at least as deep as the credit round trip, or throughput is lost.
- **On/off mode.** The receiver raises a one-bit stop flag per VC once occupancy reaches a threshold. The sender only obeys that flag. This needs no counters at the sender. The price is that the slots above the threshold are held in reserve and not used for streaming. The threshold is set to depth minus the link round trip, so flits already in flight when the stop is raised still fit.

Top module: `lfc_link`

## Requirements
- R1: After reset every sender credit count equals DEPTH, every receiver occupancy is 0, and `crd_ret`, `stop_out`, `crd_err` and `ovf_err` are all low.
- R2: In credit mode (`fc_mode`=0), `src_ok` is high exactly when the credit count of the VC on `src_vc` is nonzero. `tx_valid` equals `src_valid & src_ok`, and `tx_vc` follows `src_vc`.
- R3: In credit mode a VC's count drops by one in the cycle after a send on it, and rises by one in the cycle after a `crd_in` pulse for it. A send and a credit on the same VC in the same cycle leave the count unchanged.
- R4: In credit mode, a credit on a VC whose count is already DEPTH, with no send on that VC, raises `crd_err` for one cycle in the next cycle and leaves the count at DEPTH.
- R5: A receiver VC's occupancy rises by one the cycle after an arrival (`rx_valid` with `rx_vc`). It falls by one the cycle after a drain (`drain_valid` with `drain_vc`). A drain of an empty VC is ignored. An arrival and a drain together leave it unchanged.
- R6: In credit mode, an accepted drain on VC v makes `crd_ret[v]` high for exactly the next cycle. In on/off mode `crd_ret` stays low.
- R7: In on/off mode (`fc_mode`=1), `stop_out[v]` is high in a cycle exactly when VC v's occupancy in that cycle is at least OFF_LVL = DEPTH − LINK_RTT. In credit mode `stop_out` stays low.
- R8: In on/off mode, `src_ok` equals the inverse of `stop_in` for the VC on `src_vc`. The credit counts are frozen, and `crd_in` pulses change nothing and raise no `crd_err`.
- R9: An arrival on a VC whose occupancy is DEPTH, with no drain on it, raises `ovf_err` for one cycle in the next cycle and leaves the occupancy at DEPTH.
- R10: In on/off mode, with a link of one forward and one return stage (LINK_RTT = 2), a sender that streams without pause never causes `ovf_err`.
- R11: VCs are independent: activity on one VC never changes the count or occupancy of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_mode | input | 1 | 0 = credit counting, 1 = on/off threshold |
| src_valid | input | 1 | A flit is offered for sending |
| src_vc | input | VCW | VC of the offered flit |
| src_ok | output | 1 | The offered VC may send this cycle |
| tx_valid | output | 1 | A flit leaves onto the link this cycle |
| tx_vc | output | VCW | VC of the flit on the link |
| rx_valid | input | 1 | A flit arrives at the downstream buffer |
| rx_vc | input | VCW | VC of the arriving flit |
| drain_valid | input | 1 | The downstream consumer frees one slot |
| drain_vc | input | VCW | VC whose slot is freed |
| crd_ret | output | NVC | Credit pulses from the receiver, one bit per VC |
| stop_out | output | NVC | On/off stop flags from the receiver, one bit per VC |
| crd_in | input | NVC | Credit pulses arriving at the sender |
| stop_in | input | NVC | Stop flags arriving at the sender |
| credit_cnt | output | NVC*CW | Sender credit counts; VC v at bits [v*CW +: CW] |
| rx_occ | output | NVC*CW | Receiver occupancies; VC v at bits [v*CW +: CW] |
| crd_err | output | 1 | One-cycle pulse: a credit arrived above DEPTH |
| ovf_err | output | 1 | One-cycle pulse: an arrival hit a full buffer |

## Verification
A wrong credit counter shows up within one cycle on `credit_cnt`. A few cycles later it shows up on `src_ok`, which then either lets a flit through with no credit left or holds back a VC that still has credit. The next arrival past depth then shows on `ovf_err`. A wrong occupancy count shows up the next cycle on `rx_occ`, and through `stop_out` or `crd_ret` one cycle after the bad update. A stop flag that is too late or too low reaches `ovf_err` within about one link round trip of a continuous stream.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic {
        FC_CREDIT = 1'b0,
        FC_ONOFF  = 1'b1
    } fc_mode_e;

    // One counter update request: take = one slot consumed, give = one slot returned.
    typedef struct packed {
        logic take;
        logic give;
    } cnt_step_t;

    // Stop level: leave room for every flit that can still be in flight
    // during one full forward-plus-return trip of the link.
    function automatic int unsigned off_level(int unsigned depth, int unsigned rtt);
        return (depth > rtt) ? (depth - rtt) : 1;
    endfunction

    function automatic int unsigned sel_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lfc_credit_ctr.sv
module lfc_credit_ctr
    import lfc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fc_mode_e      mode,
    input  cnt_step_t     step,
    output logic [CW-1:0] cnt,
    output logic          err
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic full;
    assign full = (cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= FULL;
            err <= 1'b0;
        end else begin
            err <= 1'b0;
            if (mode == FC_CREDIT) begin
                unique case ({step.take, step.give})
                    2'b10: cnt <= cnt - 1'b1;
                    2'b01: begin
                        if (full) err <= 1'b1;
                        else      cnt <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_dec_on_send_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_CREDIT && step.take && !step.give) |=> (cnt == $past(cnt) - 1'b1));

    assert_send_and_credit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_CREDIT && step.take && step.give) |=> $stable(cnt));

    assert_excess_credit_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_CREDIT && step.give && !step.take && cnt == FULL) |=> (err && cnt == FULL));

    assert_frozen_onoff_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_ONOFF) |=> $stable(cnt));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

endmodule

// File: rtl/lfc_occ_ctr.sv
module lfc_occ_ctr
    import lfc_pkg::*;
#(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned OFF_LVL = 6,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fc_mode_e      mode,
    input  logic          arrive,
    input  logic          drain,
    output logic [CW-1:0] occ,
    output logic          crd_ret,
    output logic          stop,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] OFF  = CW'(OFF_LVL);

    logic          drn_ok;
    logic [CW-1:0] occ_nx;
    logic          ovf_nx;

    assign drn_ok = drain && (occ != '0);

    always_comb begin
        occ_nx = occ;
        ovf_nx = 1'b0;
        unique case ({arrive, drn_ok})
            2'b10: begin
                if (occ == FULL) ovf_nx = 1'b1;
                else             occ_nx = occ + 1'b1;
            end
            2'b01:   occ_nx = occ - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ     <= '0;
            crd_ret <= 1'b0;
            stop    <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            occ     <= occ_nx;
            ovf     <= ovf_nx;
            crd_ret <= (mode == FC_CREDIT) && drn_ok;
            stop    <= (mode == FC_ONOFF) && (occ_nx >= OFF);
        end
    end

    assert_ret_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
        crd_ret |-> $past(drain && occ != '0));

    assert_stop_level_R7: assert property (@(posedge clk) disable iff (rst)
        stop |-> (occ >= OFF));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (arrive && !drain && occ == FULL) |=> (ovf && occ == FULL));

    assert_empty_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (drain && !arrive && occ == '0) |=> (occ == '0 && !crd_ret));

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL);

endmodule

// File: rtl/lfc_tx_gate.sv
module lfc_tx_gate
    import lfc_pkg::*;
#(
    parameter int unsigned NVC = 4,
    localparam int unsigned VCW = sel_width(NVC)
) (
    input  fc_mode_e         mode,
    input  logic             src_valid,
    input  logic [VCW-1:0]   src_vc,
    input  logic [NVC-1:0]   has_credit,
    input  logic [NVC-1:0]   stop_in,
    output logic             ok,
    output logic             fire,
    output logic [NVC-1:0]   fire_vec
);
    always_comb begin
        if (mode == FC_CREDIT) ok = has_credit[src_vc];
        else                   ok = !stop_in[src_vc];
        fire = src_valid && ok;
        for (int v = 0; v < NVC; v++) begin
            fire_vec[v] = fire && (src_vc == VCW'(v));
        end
    end

endmodule

// File: rtl/lfc_link.sv
module lfc_link
    import lfc_pkg::*;
#(
    parameter int unsigned NVC      = 4,
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned LINK_RTT = 2,
    localparam int unsigned VCW     = sel_width(NVC),
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fc_mode,
    input  logic               src_valid,
    input  logic [VCW-1:0]     src_vc,
    output logic               src_ok,
    output logic               tx_valid,
    output logic [VCW-1:0]     tx_vc,
    input  logic               rx_valid,
    input  logic [VCW-1:0]     rx_vc,
    input  logic               drain_valid,
    input  logic [VCW-1:0]     drain_vc,
    output logic [NVC-1:0]     crd_ret,
    output logic [NVC-1:0]     stop_out,
    input  logic [NVC-1:0]     crd_in,
    input  logic [NVC-1:0]     stop_in,
    output logic [NVC*CW-1:0]  credit_cnt,
    output logic [NVC*CW-1:0]  rx_occ,
    output logic               crd_err,
    output logic               ovf_err
);
    localparam int unsigned OFF_LVL = off_level(DEPTH, LINK_RTT);

    fc_mode_e       mode;
    logic           fire;
    logic [NVC-1:0] fire_vec;
    logic [NVC-1:0] has_credit;
    logic [NVC-1:0] cerr_vec;
    logic [NVC-1:0] oerr_vec;

    assign mode  = fc_mode_e'(fc_mode);
    assign tx_valid = fire;
    assign tx_vc    = src_vc;

    lfc_tx_gate #(.NVC(NVC)) u_gate (
        .mode       (mode),
        .src_valid  (src_valid),
        .src_vc     (src_vc),
        .has_credit (has_credit),
        .stop_in    (stop_in),
        .ok         (src_ok),
        .fire       (fire),
        .fire_vec   (fire_vec)
    );

    for (genvar v = 0; v < NVC; v++) begin : g_vc
        cnt_step_t     step;
        logic [CW-1:0] cnt;
        logic [CW-1:0] occ;

        assign step.take = fire_vec[v];
        assign step.give = crd_in[v];

        lfc_credit_ctr #(.DEPTH(DEPTH)) u_credit (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .step (step),
            .cnt  (cnt),
            .err  (cerr_vec[v])
        );

        lfc_occ_ctr #(.DEPTH(DEPTH), .OFF_LVL(OFF_LVL)) u_occ (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .arrive  (rx_valid && (rx_vc == VCW'(v))),
            .drain   (drain_valid && (drain_vc == VCW'(v))),
            .occ     (occ),
            .crd_ret (crd_ret[v]),
            .stop    (stop_out[v]),
            .ovf     (oerr_vec[v])
        );

        assign has_credit[v]          = (cnt != '0);
        assign credit_cnt[v*CW +: CW] = cnt;
        assign rx_occ[v*CW +: CW]     = occ;
    end

    assign crd_err = |cerr_vec;
    assign ovf_err = |oerr_vec;

    assert_single_return_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(crd_ret));

    assert_no_stop_credit_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_CREDIT) |=> (stop_out == '0));

    assert_send_needs_credit_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == FC_CREDIT && tx_valid) |-> (credit_cnt[tx_vc*CW +: CW] != '0));

endmodule

// File: tb/lfc_link_tb.sv
`timescale 1ns/1ps
module lfc_link_tb;
    localparam int NVC = 4;
    localparam int DEPTH = 8;
    localparam int RTT = 2;
    localparam int VCW = 2;
    localparam int CW = 4;
    localparam int OFF = DEPTH - RTT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fc_mode = 1'b0;
    logic src_valid = 1'b0;
    logic [VCW-1:0] src_vc = '0;
    logic src_ok, tx_valid;
    logic [VCW-1:0] tx_vc;
    logic rx_valid = 1'b0;
    logic [VCW-1:0] rx_vc = '0;
    logic drain_valid = 1'b0;
    logic [VCW-1:0] drain_vc = '0;
    logic [NVC-1:0] crd_ret, stop_out;
    logic [NVC-1:0] crd_in = '0;
    logic [NVC-1:0] stop_in = '0;
    logic [NVC*CW-1:0] credit_cnt, rx_occ;
    logic crd_err, ovf_err;

    always #4 clk = ~clk;

    lfc_link #(.NVC(NVC), .DEPTH(DEPTH), .LINK_RTT(RTT)) u_dut (
        .clk(clk), .rst(rst), .fc_mode(fc_mode),
        .src_valid(src_valid), .src_vc(src_vc), .src_ok(src_ok),
        .tx_valid(tx_valid), .tx_vc(tx_vc),
        .rx_valid(rx_valid), .rx_vc(rx_vc),
        .drain_valid(drain_valid), .drain_vc(drain_vc),
        .crd_ret(crd_ret), .stop_out(stop_out),
        .crd_in(crd_in), .stop_in(stop_in),
        .credit_cnt(credit_cnt), .rx_occ(rx_occ),
        .crd_err(crd_err), .ovf_err(ovf_err)
    );

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_cnt[NVC];
    int m_occ[NVC];
    bit [NVC-1:0] m_ret, m_stop;
    bit m_cerr, m_oerr;
    // link pipeline in the bench: one forward stage, one return stage
    bit p_fv;
    int p_fvc;
    bit [NVC-1:0] p_ret, p_stop;
    bit [15:0] lfsr = 16'hACE1;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < NVC; v++) begin
            m_cnt[v] = DEPTH;
            m_occ[v] = 0;
        end
        m_ret = '0; m_stop = '0; m_cerr = 0; m_oerr = 0;
        p_fv = 0; p_fvc = 0; p_ret = '0; p_stop = '0;
    endtask

    task automatic do_reset(bit md);
        @(negedge clk);
        rst = 1'b1; fc_mode = md;
        src_valid = 0; drain_valid = 0; rx_valid = 0; crd_in = '0; stop_in = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state
        for (int v = 0; v < NVC; v++) begin
            chk("R1", "count", int'(credit_cnt[v*CW +: CW]), DEPTH);
            chk("R1", "occupancy", int'(rx_occ[v*CW +: CW]), 0);
        end
        chk("R1", "crd_ret", int'(crd_ret), 0);
        chk("R1", "stop_out", int'(stop_out), 0);
        chk("R1", "errors", int'({crd_err, ovf_err}), 0);
    endtask

    // One link cycle: drive, compare against the model, advance the model.
    task automatic cyc(bit sv, int svc, bit dv, int dvc,
                       bit [NVC-1:0] inj_crd, bit inj_rx, int inj_vc);
        bit ok, fire, rxv, arr, drn, ncerr, noerr;
        bit [NVC-1:0] nret, nstop, cin;
        int rxvc;
        @(negedge clk);
        src_valid = sv; src_vc = VCW'(svc);
        drain_valid = dv; drain_vc = VCW'(dvc);
        rxv = p_fv | inj_rx;
        rxvc = inj_rx ? inj_vc : p_fvc;
        rx_valid = rxv; rx_vc = VCW'(rxvc);
        cin = p_ret | inj_crd;
        crd_in = cin;
        stop_in = p_stop;
        #1;
        ok = fc_mode ? !p_stop[svc] : (m_cnt[svc] != 0);
        fire = sv && ok;
        chk(fc_mode ? "R8" : "R2", "src_ok", int'(src_ok), int'(ok));
        chk(fc_mode ? "R8" : "R2", "tx_valid", int'(tx_valid), int'(fire));
        if (fire) chk("R2", "tx_vc", int'(tx_vc), svc);
        for (int v = 0; v < NVC; v++) begin
            chk(fc_mode ? "R8" : "R3", "count", int'(credit_cnt[v*CW +: CW]), m_cnt[v]);
            chk("R5", "occupancy", int'(rx_occ[v*CW +: CW]), m_occ[v]);
        end
        chk("R6", "crd_ret", int'(crd_ret), int'(m_ret));
        chk("R7", "stop_out", int'(stop_out), int'(m_stop));
        chk(fc_mode ? "R8" : "R4", "crd_err", int'(crd_err), int'(m_cerr));
        chk(fc_mode ? "R10" : "R9", "ovf_err", int'(ovf_err), int'(m_oerr));
        // advance reference
        ncerr = 0; noerr = 0; nret = '0; nstop = '0;
        for (int v = 0; v < NVC; v++) begin
            bit dec, inc;
            dec = !fc_mode && fire && (svc == v);
            inc = !fc_mode && cin[v];
            if (dec && !inc) m_cnt[v]--;
            else if (inc && !dec) begin
                if (m_cnt[v] == DEPTH) ncerr = 1;
                else m_cnt[v]++;
            end
            arr = rxv && (rxvc == v);
            drn = dv && (dvc == v) && (m_occ[v] > 0);
            if (arr && !drn) begin
                if (m_occ[v] == DEPTH) noerr = 1;
                else m_occ[v]++;
            end else if (drn && !arr) m_occ[v]--;
            nret[v] = !fc_mode && drn;
            nstop[v] = fc_mode && (m_occ[v] >= OFF);
        end
        p_fv = fire; p_fvc = svc;
        p_ret = m_ret; p_stop = m_stop;
        m_ret = nret; m_stop = nstop; m_cerr = ncerr; m_oerr = noerr;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, 0, 0);
    endtask

    task automatic random_phase(int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            // R11: mixed traffic across all VCs at once
            cyc(lfsr[0] | lfsr[3], int'(lfsr[5:4]), lfsr[7] & (lfsr[1] | lfsr[9]),
                int'(lfsr[11:10]), '0, 0, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // ---------------- credit mode ----------------
        do_reset(1'b0);
        // R4: credit on a full counter
        cyc(0, 0, 0, 0, 4'b0001, 0, 0);
        idle(2);
        // R2, R3: stream VC1 until out of credit
        for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, '0, 0, 0);
        idle(2);
        // R11: other VCs untouched
        chk("R11", "vc0 count", int'(credit_cnt[0 +: CW]), DEPTH);
        chk("R11", "vc0 occupancy", int'(rx_occ[0 +: CW]), 0);
        // R9: extra flit into full VC1 buffer
        cyc(0, 0, 0, 0, '0, 1, 1);
        idle(1);
        // R6: drain VC1, credits return
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, '0, 0, 0);
        idle(3);
        // R3: send and credit together on VC2 in steady state
        for (int i = 0; i < 4; i++) cyc(1, 2, 0, 0, '0, 0, 0);
        for (int i = 0; i < 16; i++) cyc(1, 2, 1, 2, '0, 0, 0);
        // R5: drain of empty VC3 ignored
        cyc(0, 0, 1, 3, '0, 0, 0);
        idle(2);
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, i % NVC, '0, 0, 0);
        random_phase(400);
        // ---------------- on/off mode ----------------
        do_reset(1'b1);
        // R7, R10: continuous stream on VC0 with no drain
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, '0, 0, 0);
        // R8: credit pulses ignored
        cyc(1, 0, 0, 0, 4'b1111, 0, 0);
        idle(2);
        // release by draining
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, '0, 0, 0);
        idle(3);
        for (int i = 0; i < 30; i++) cyc(1, 3, i % 3 == 0, 3, '0, 0, 0);
        random_phase(400);
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule